// File: doc/BRIEF.md
# Tile Colour Buffer with Row-Ordered Writeback

This block keeps one screen tile of 16-bit colour pixels in on-chip registers while the rasterizer draws every triangle that touches that tile. A pixel write names a position inside the tile and a colour, and it lands in one cycle wherever it falls. Local storage has no page penalty, so small triangles that scatter writes across many rows cost nothing extra.

When the last triangle of the tile has been drawn, a flush command copies the tile to a linear framebuffer in external memory. The framebuffer runs left to right along a line, then downward line by line. The copy goes out as full 128-bit bus words over a valid/ready write port. Words leave in row order, and every address is computed from a framebuffer base, a line pitch in bytes and the tile's grid position. Each word is fully populated. After the copy, the buffer is refilled with a programmable clear colour so the next tile can start at once.

Top module: `tile_store_flush`

## Requirements
- R1: After reset, `busy`, `mw_valid` and `done` are low and every pixel of the buffer holds 0x0000.
- R2: A pixel write (`px_valid` high while `busy` is low) stores `px_color` at column `px_x`, row `px_y`. A later write to the same position replaces the earlier colour.
- R3: A `flush` sampled high while idle makes `busy` and `mw_valid` high from the next cycle.
- R4: A flush issues exactly 64 accepted words: rows 0 to 15 top to bottom, and 4 words per row left to right (word n covers row n/4, columns 8*(n%4) to 8*(n%4)+7).
- R5: In each word, bits [16k+15:16k] hold the pixel at column 8*(n%4)+k of that row, so the leftmost pixel is in the lowest bits.
- R6: The address of word n is `fb_base` + (`tile_y`*16 + n/4)*`fb_pitch` + `tile_x`*64 + (n%4)*16, in bytes. The address inputs are taken when the flush starts.
- R7: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold their values.
- R8: Pixel writes offered while `busy` is high are dropped and do not change the buffer.
- R9: A `flush` asserted while `busy` is high has no effect; no extra words follow the current flush.
- R10: `done` is high for exactly one cycle: the cycle after the 64th word is accepted. In that cycle `busy` and `mw_valid` are already low.
- R11: When the 64th word is accepted, every pixel is set to the `clear_color` value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_valid | input | 1 | Pixel write request |
| px_x | input | 5 | Pixel column inside tile |
| px_y | input | 4 | Pixel row inside tile |
| px_color | input | 16 | Pixel colour |
| busy | output | 1 | Flush in progress, pixel writes refused |
| flush | input | 1 | Start copying the tile to memory |
| fb_base | input | 32 | Framebuffer byte base address |
| fb_pitch | input | 32 | Framebuffer line pitch in bytes |
| tile_x | input | 12 | Tile column in the tile grid |
| tile_y | input | 12 | Tile row in the tile grid |
| clear_color | input | 16 | Colour loaded into the buffer after a flush |
| mw_valid | output | 1 | Memory write word valid |
| mw_addr | output | 32 | Memory write byte address |
| mw_data | output | 128 | Memory write data, eight pixels |
| mw_ready | input | 1 | Memory port accepts the word |
| done | output | 1 | One-cycle pulse after the last word is accepted |

## Verification
A wrong word counter shows at the memory port within one accepted word: the address moves off the row formula or the data carries pixels from the wrong columns. A corrupted pixel stays hidden until the next flush, where it appears in exactly one word. A faulty clear shows on the flush of the following tile. Refused writes and refused flush commands are checked through the words of the current and the next flush, and through a quiet port after `done`.

// File: rtl/tile_store_flush.sv
module tile_store_flush #(
  parameter int TILE_W = 32,
  parameter int TILE_H = 16,
  parameter int PIX_W  = 16,
  parameter int BUS_W  = 128,
  parameter int ADDR_W = 32,
  parameter int TC_W   = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           px_valid,
  input  logic [$clog2(TILE_W)-1:0]      px_x,
  input  logic [$clog2(TILE_H)-1:0]      px_y,
  input  logic [PIX_W-1:0]               px_color,
  output logic                           busy,
  input  logic                           flush,
  input  logic [ADDR_W-1:0]              fb_base,
  input  logic [ADDR_W-1:0]              fb_pitch,
  input  logic [TC_W-1:0]                tile_x,
  input  logic [TC_W-1:0]                tile_y,
  input  logic [PIX_W-1:0]               clear_color,
  output logic                           mw_valid,
  output logic [ADDR_W-1:0]              mw_addr,
  output logic [BUS_W-1:0]               mw_data,
  input  logic                           mw_ready,
  output logic                           done
);
  localparam int NPIX   = TILE_W * TILE_H;
  localparam int PPW    = BUS_W / PIX_W;
  localparam int WPR    = TILE_W / PPW;
  localparam int NWORDS = NPIX / PPW;
  localparam int KW     = $clog2(PPW);
  localparam int CW     = $clog2(NWORDS);
  localparam int WCW    = $clog2(WPR);
  localparam int IW     = $clog2(NPIX);
  localparam logic [ADDR_W-1:0] TILE_ROW_BYTES = ADDR_W'(TILE_W * PIX_W / 8);
  localparam logic [ADDR_W-1:0] WORD_BYTES     = ADDR_W'(BUS_W / 8);
  localparam logic [ADDR_W-1:0] TILE_LINES     = ADDR_W'(TILE_H);

  logic [PIX_W-1:0]  pix [NPIX];
  logic [CW-1:0]     wcnt;
  logic [ADDR_W-1:0] org_q, pitch_q;
  logic              acc, last_acc;

  assign acc      = busy & mw_ready;
  assign last_acc = acc & (wcnt == CW'(NWORDS - 1));
  assign mw_valid = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      wcnt    <= '0;
      org_q   <= '0;
      pitch_q <= '0;
    end else begin
      done <= last_acc;
      if (!busy && flush) begin
        busy    <= 1'b1;
        wcnt    <= '0;
        pitch_q <= fb_pitch;
        org_q   <= fb_base + ADDR_W'(tile_y) * TILE_LINES * fb_pitch
                   + ADDR_W'(tile_x) * TILE_ROW_BYTES;
      end else if (last_acc) begin
        busy <= 1'b0;
        wcnt <= '0;
      end else if (acc) begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) pix[i] <= '0;
    end else if (last_acc) begin
      for (int i = 0; i < NPIX; i++) pix[i] <= clear_color;
    end else if (px_valid && !busy) begin
      pix[IW'({px_y, px_x})] <= px_color;
    end
  end

  assign mw_addr = org_q + ADDR_W'(wcnt[CW-1:WCW]) * pitch_q
                   + ADDR_W'(wcnt[WCW-1:0]) * WORD_BYTES;

  for (genvar k = 0; k < PPW; k++) begin : g_lane
    assign mw_data[k*PIX_W +: PIX_W] = pix[IW'({wcnt, KW'(k)})];
  end
endmodule

// File: rtl/tile_store_flush_chk.sv
module tile_store_flush_chk #(
  parameter int BUS_W  = 128,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              busy,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [ADDR_W-1:0] mw_addr,
  input logic [BUS_W-1:0]  mw_data,
  input logic              done
);
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  a_r3_start_needs_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(flush));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mw_valid));

  a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mw_valid && mw_ready));
endmodule

bind tile_store_flush tile_store_flush_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .busy(busy), .mw_valid(mw_valid),
  .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data), .done(done)
);

// File: tb/tile_store_flush_tb.sv
module tile_store_flush_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         px_valid = 1'b0;
  logic [4:0]   px_x = '0;
  logic [3:0]   px_y = '0;
  logic [15:0]  px_color = '0;
  logic         busy;
  logic         flush = 1'b0;
  logic [31:0]  fb_base = '0;
  logic [31:0]  fb_pitch = '0;
  logic [11:0]  tile_x = '0;
  logic [11:0]  tile_y = '0;
  logic [15:0]  clear_color = '0;
  logic         mw_valid;
  logic [31:0]  mw_addr;
  logic [127:0] mw_data;
  logic         mw_ready = 1'b0;
  logic         done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] model [512];

  // {x[4:0], y[3:0], colour[15:0]}
  localparam logic [24:0] VEC [12] = '{
    {5'd0,  4'd0,  16'hA001}, {5'd31, 4'd15, 16'hA002},
    {5'd7,  4'd0,  16'hA003}, {5'd8,  4'd0,  16'hA004},
    {5'd31, 4'd0,  16'hA005}, {5'd0,  4'd15, 16'hA006},
    {5'd5,  4'd9,  16'hA007}, {5'd5,  4'd9,  16'hA008},
    {5'd16, 4'd7,  16'hA009}, {5'd24, 4'd3,  16'hA00A},
    {5'd15, 4'd8,  16'hA00B}, {5'd1,  4'd1,  16'hA00C}
  };

  tile_store_flush u_dut (
    .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
    .px_color(px_color), .busy(busy), .flush(flush), .fb_base(fb_base),
    .fb_pitch(fb_pitch), .tile_x(tile_x), .tile_y(tile_y),
    .clear_color(clear_color), .mw_valid(mw_valid), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_ready(mw_ready), .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_word(input int n);
    logic [127:0] w;
    for (int k = 0; k < 8; k++) w[k*16 +: 16] = model[(n / 4) * 32 + (n % 4) * 8 + k];
    return w;
  endfunction

  task automatic run_flush(input logic [11:0] tx, input logic [11:0] ty,
                           input logic [31:0] base, input logic [31:0] pitch, input bit inject);
    int nacc = 0;
    bit stalled = 0;
    logic [31:0]  s_addr = '0;
    logic [127:0] s_data = '0;
    logic [31:0]  ea;
    @(negedge clk);
    tile_x = tx; tile_y = ty; fb_base = base; fb_pitch = pitch; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    fb_base = 32'hDEAD_0000; tile_x = 12'd77;
    chk(busy && mw_valid, "R3 busy/valid after flush", {busy, mw_valid}, 2'b11);
    for (int it = 0; it < 1000 && nacc < 64; it++) begin
      if (it > 0) @(negedge clk);
      px_valid = 1'b0; flush = 1'b0;
      mw_ready = (it % 3 != 1);
      if (inject && it == 5) begin px_valid = 1'b1; px_x = 5'd3; px_y = 4'd3; px_color = 16'hBEEF; end
      if (inject && it == 10) flush = 1'b1;
      #1;
      if (stalled)
        chk(mw_valid && mw_addr == s_addr && mw_data == s_data, "R7 hold under stall",
            {mw_addr, mw_data[95:0]}, {s_addr, s_data[95:0]});
      stalled = mw_valid && !mw_ready;
      s_addr = mw_addr; s_data = mw_data;
      if (mw_valid && mw_ready) begin
        ea = base + (32'(ty) * 16 + 32'(nacc / 4)) * pitch + 32'(tx) * 64 + 32'(nacc % 4) * 16;
        chk(mw_addr == ea, "R6 word address", mw_addr, ea);
        chk(mw_data == exp_word(nacc), "R4/R5 word data", mw_data, exp_word(nacc));
        nacc++;
      end
    end
    chk(nacc == 64, "R4 word count", nacc, 64);
    @(negedge clk);
    px_valid = 1'b0; flush = 1'b0; mw_ready = 1'b1;
    chk(done && !busy && !mw_valid, "R10 done pulse after last word",
        {done, busy, mw_valid}, 3'b100);
    @(negedge clk);
    chk(!done, "R10 done is one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(!mw_valid && !busy, "R9 no extra flush", {mw_valid, busy}, 2'b00);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 16'h0000;
    repeat (2) @(negedge clk);
    chk(!busy && !mw_valid && !done, "R1 reset outputs", {busy, mw_valid, done}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mw_valid && !done, "R1 idle after reset", {busy, mw_valid, done}, 3'b000);

    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      chk(!busy, "R2 idle for write", busy, 0);
      px_valid = 1'b1;
      px_x = VEC[v][24:20]; px_y = VEC[v][19:16]; px_color = VEC[v][15:0];
      model[{VEC[v][19:16], VEC[v][24:20]}] = VEC[v][15:0];
    end
    @(negedge clk);
    px_valid = 1'b0;

    clear_color = 16'h1F1F;
    // R1 R2 R4 R5 R6 R8 R9 R10: first tile with injected refused write and flush
    run_flush(12'd2, 12'd1, 32'h1000_0000, 32'h0000_1000, 1'b1);

    // R11: buffer now holds the clear colour present at completion
    clear_color = 16'h07E0;
    for (int i = 0; i < 512; i++) model[i] = 16'h1F1F;
    run_flush(12'd0, 12'd3, 32'h2000_0000, 32'd1280, 1'b0);

    // R2 after clear: write corner then flush with the new clear colour pending
    for (int i = 0; i < 512; i++) model[i] = 16'h07E0;
    @(negedge clk);
    px_valid = 1'b1; px_x = 5'd31; px_y = 4'd15; px_color = 16'h1234;
    model[{4'd15, 5'd31}] = 16'h1234;
    @(negedge clk);
    px_valid = 1'b0;
    run_flush(12'd5, 12'd0, 32'h0000_0040, 32'd2560, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule